// File: doc/BRIEF.md
# Grouped Six-Channel Compare Timer

This block contains six 16-bit up-counters. Each counter has two compare registers and drives one output pin. Two byte-wide common registers control all the channels. The run register starts or halts each counter separately. The group register places channels into a lock-step set. While the set is active, a write to the counter of any member loads the same value into every member in the same clock edge. A clear that one member causes by its own compare match can also reset the other members, if those members are configured to follow it.

Each channel has a control word with three fields:
- a clear-source field;
- a pin action applied on compare match A;
- an initial pin level.

When the channel is halted, the pin keeps the level it reached last. The pin changes only when software writes the control word, which loads the initial level. A simple register bus gives single-cycle write access and combinational read access to every register.

Top module: `mtimer_top`

## Requirements
- R1: The run register is at address 0x00. Bit n (n = 0..5) enables channel n. Read data bits 15..6 are always 0, and written values in bits 7..6 are discarded. The register resets to 0.
- R2: A counter whose run bit is 1 increments by one on each clock and wraps from 0xFFFF to 0x0000. A counter whose run bit is 0 holds its value. A run-bit write affects counting from the next edge on.
- R3: The group register is at address 0x01. Bit n places channel n in the group. Read data bits 15..6 are always 0, and written values in bits 7..6 are discarded. The register resets to 0.
- R4: The group is active only when at least two group bits are 1. While the group is active, a counter write to any member loads the written value into all members on the same edge. A counter write to any other channel loads only that channel.
- R5: Channel n's registers are at 0x10+4n, in this order: counter (+0), compare A (+1), compare B (+2), control (+3). The control fields are:
  - bits 2..0: clear source;
  - bits 4..3: pin action;
  - bit 5: initial level.

  After reset, counters are 0, compares are 0xFFFF, control words are 0 and pins are 0.
- R6: A match is declared when the run bit is 1 and the counter equals a compare register. Clear source 001 clears the counter on match A, and 010 clears it on match B. After the clearing edge the counter reads 0. Source 000 never clears.
- R7: A channel with clear source 011 clears when an active-group member clears itself by its own match. This happens only if the channel is itself in the active group. A group member with any other clear source is not cleared by this.
- R8: On match A the pin action is applied: 00 keeps the level, 01 drives 0, 10 drives 1, 11 toggles.
- R9: A halted channel keeps its pin level. A control write while the run bit is 0 sets the pin to the written bit 5. A control write while running leaves the pin unchanged.
- R10: A counter write takes priority over both clearing and incrementing on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational, 0 when busSel is low |
| tmrOut | output | 6 | Channel output pins |

## Verification
The bench writes to the counter of one group member and reads back every other member. This exposes a design that loads only the addressed channel, or one that broadcasts even when only a single group bit is set. It builds a group that mixes a follower with source 011, a member that never clears and a non-member with source 011. A design that treats group membership alone as a clear source, or that ignores the active-group rule, then leaves wrong counter values. It halts channels and writes control words both while halted and while running. A design that resets the pin on stop, or that reloads it while running, then shows a pin mismatch. Finally, it writes a counter on the same edge where that counter would clear, to expose a wrong priority.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int CH_NUM   = 6;
  localparam int CNT_W    = 16;
  localparam int CLR_W    = 3;
  localparam int ACT_W    = 2;
  localparam int INIT_BIT = CLR_W + ACT_W;
  localparam int CTL_W    = INIT_BIT + 1;

  localparam int OFF_CNT  = 0;
  localparam int OFF_CMPA = 1;
  localparam int OFF_CMPB = 2;
  localparam int OFF_CTL  = 3;

  localparam logic [CLR_W-1:0] CLR_NONE = 3'd0;
  localparam logic [CLR_W-1:0] CLR_MA   = 3'd1;
  localparam logic [CLR_W-1:0] CLR_MB   = 3'd2;
  localparam logic [CLR_W-1:0] CLR_GRP  = 3'd3;

  localparam logic [ACT_W-1:0] ACT_KEEP = 2'd0;
  localparam logic [ACT_W-1:0] ACT_LOW  = 2'd1;
  localparam logic [ACT_W-1:0] ACT_HIGH = 2'd2;
  localparam logic [ACT_W-1:0] ACT_TGL  = 2'd3;

  typedef struct packed {
    logic [CH_NUM-1:0] ldCnt;
    logic [CH_NUM-1:0] ldCmpA;
    logic [CH_NUM-1:0] ldCmpB;
    logic [CH_NUM-1:0] ldCtl;
    logic [CH_NUM-1:0] runEn;
    logic [CH_NUM-1:0] inGrp;
  } strobe_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int START_ADDR = 0,
  parameter int SYNC_ADDR  = 1,
  parameter int CH_BASE    = 16,
  parameter int CH_STRIDE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output strobe_t           strb,
  output logic [CH_NUM-1:0] startReg,
  output logic [CH_NUM-1:0] syncReg,
  output logic              commonHit,
  output logic [CNT_W-1:0]  commonRdata
);
  localparam int GRP_MIN = 2;
  localparam int PAD_W   = CNT_W - CH_NUM;

  logic              wrEn, startHit, syncHit, grpOn, grpLoad;
  logic [CH_NUM-1:0] grpMask, wrCnt, wrCmpA, wrCmpB, wrCtl;

  assign wrEn     = busSel & busWr;
  assign startHit = (busAddr == ADDR_W'(START_ADDR));
  assign syncHit  = (busAddr == ADDR_W'(SYNC_ADDR));

  // R1 R3: only the six channel bits are stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      syncReg  <= '0;
    end else begin
      if (wrEn && startHit) startReg <= busWdata[CH_NUM-1:0];
      if (wrEn && syncHit)  syncReg  <= busWdata[CH_NUM-1:0];
    end
  end

  // R4: the group needs at least two members
  assign grpOn   = ($countones(syncReg) >= GRP_MIN);
  assign grpMask = grpOn ? syncReg : '0;

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_dec
    localparam int BASE = CH_BASE + ch * CH_STRIDE;
    assign wrCnt[ch]  = wrEn && (busAddr == ADDR_W'(BASE + OFF_CNT));
    assign wrCmpA[ch] = wrEn && (busAddr == ADDR_W'(BASE + OFF_CMPA));
    assign wrCmpB[ch] = wrEn && (busAddr == ADDR_W'(BASE + OFF_CMPB));
    assign wrCtl[ch]  = wrEn && (busAddr == ADDR_W'(BASE + OFF_CTL));
  end

  assign grpLoad = |(wrCnt & grpMask);

  assign strb = '{
    ldCnt:  wrCnt | (grpMask & {CH_NUM{grpLoad}}),
    ldCmpA: wrCmpA,
    ldCmpB: wrCmpB,
    ldCtl:  wrCtl,
    runEn:  startReg,
    inGrp:  grpMask
  };

  assign commonHit   = startHit | syncHit;
  assign commonRdata = startHit ? {{PAD_W{1'b0}}, startReg} :
                       syncHit  ? {{PAD_W{1'b0}}, syncReg}  : '0;
endmodule

// File: rtl/mtimer_datapath.sv
module mtimer_datapath
  import mtimer_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CH_BASE   = 16,
  parameter int CH_STRIDE = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [CNT_W-1:0]              busWdata,
  output logic [CH_NUM-1:0]             tmrOut,
  output logic [CH_NUM-1:0][CNT_W-1:0]  cntFlat,
  output logic                          chHit,
  output logic [CNT_W-1:0]              chRdata
);
  localparam int PAD_W = CNT_W - CTL_W;

  logic [CH_NUM-1:0][CNT_W-1:0] cmpA, cmpB;
  logic [CH_NUM-1:0][CTL_W-1:0] ctl;
  logic [CH_NUM-1:0]            matchA, matchB, ownClr, clrNow;
  logic                         grpClr;

  // R7: a self-clear by any active member is broadcast
  assign grpClr = |(ownClr & strb.inGrp);

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
    logic [CLR_W-1:0] clrSel;
    logic [ACT_W-1:0] act;

    assign clrSel = ctl[ch][CLR_W-1:0];
    assign act    = ctl[ch][CLR_W +: ACT_W];

    // R6
    assign matchA[ch] = strb.runEn[ch] && (cntFlat[ch] == cmpA[ch]);
    assign matchB[ch] = strb.runEn[ch] && (cntFlat[ch] == cmpB[ch]);
    assign ownClr[ch] = ((clrSel == CLR_MA) && matchA[ch]) ||
                        ((clrSel == CLR_MB) && matchB[ch]);
    assign clrNow[ch] = ownClr[ch] ||
                        ((clrSel == CLR_GRP) && strb.inGrp[ch] && grpClr);

    // R2 R10: load, then clear, then increment
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  cntFlat[ch] <= '0;
      else if (strb.ldCnt[ch])    cntFlat[ch] <= busWdata;
      else if (clrNow[ch])        cntFlat[ch] <= '0;
      else if (strb.runEn[ch])    cntFlat[ch] <= cntFlat[ch] + 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpA[ch] <= '1;
        cmpB[ch] <= '1;
        ctl[ch]  <= '0;
      end else begin
        if (strb.ldCmpA[ch]) cmpA[ch] <= busWdata;
        if (strb.ldCmpB[ch]) cmpB[ch] <= busWdata;
        if (strb.ldCtl[ch])  ctl[ch]  <= busWdata[CTL_W-1:0];
      end
    end

    // R8 R9: pin level
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tmrOut[ch] <= 1'b0;
      else if (strb.ldCtl[ch] && !strb.runEn[ch]) tmrOut[ch] <= busWdata[INIT_BIT];
      else if (matchA[ch]) begin
        case (act)
          ACT_LOW:  tmrOut[ch] <= 1'b0;
          ACT_HIGH: tmrOut[ch] <= 1'b1;
          ACT_TGL:  tmrOut[ch] <= ~tmrOut[ch];
          default:  tmrOut[ch] <= tmrOut[ch];
        endcase
      end
    end
  end

  always_comb begin
    chHit   = 1'b0;
    chRdata = '0;
    for (int c = 0; c < CH_NUM; c++) begin
      if (busAddr == ADDR_W'(CH_BASE + c * CH_STRIDE + OFF_CNT)) begin
        chHit = 1'b1; chRdata = cntFlat[c];
      end
      if (busAddr == ADDR_W'(CH_BASE + c * CH_STRIDE + OFF_CMPA)) begin
        chHit = 1'b1; chRdata = cmpA[c];
      end
      if (busAddr == ADDR_W'(CH_BASE + c * CH_STRIDE + OFF_CMPB)) begin
        chHit = 1'b1; chRdata = cmpB[c];
      end
      if (busAddr == ADDR_W'(CH_BASE + c * CH_STRIDE + OFF_CTL)) begin
        chHit = 1'b1; chRdata = {{PAD_W{1'b0}}, ctl[c]};
      end
    end
  end
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int START_ADDR = 0,
  parameter int SYNC_ADDR  = 1,
  parameter int CH_BASE    = 16,
  parameter int CH_STRIDE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [CH_NUM-1:0] tmrOut
);
  strobe_t                      strb;
  logic [CH_NUM-1:0]            startReg, syncReg;
  logic [CH_NUM-1:0][CNT_W-1:0] cntFlat;
  logic                         commonHit, chHit;
  logic [CNT_W-1:0]             commonRdata, chRdata;

  mtimer_ctrl #(
    .ADDR_W(ADDR_W), .START_ADDR(START_ADDR), .SYNC_ADDR(SYNC_ADDR),
    .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .strb(strb),
    .startReg(startReg), .syncReg(syncReg),
    .commonHit(commonHit), .commonRdata(commonRdata)
  );

  mtimer_datapath #(
    .ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .tmrOut(tmrOut), .cntFlat(cntFlat),
    .chHit(chHit), .chRdata(chRdata)
  );

  assign busRdata = !busSel   ? '0 :
                    commonHit ? commonRdata :
                    chHit     ? chRdata : '0;
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
  import mtimer_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int START_ADDR = 0,
  parameter int SYNC_ADDR  = 1,
  parameter int CH_BASE    = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          busSel,
  input logic                          busWr,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [CNT_W-1:0]              busWdata,
  input logic [CNT_W-1:0]              busRdata,
  input logic [CH_NUM-1:0]             tmrOut,
  input logic [CH_NUM-1:0]             startReg,
  input logic [CH_NUM-1:0]             syncReg,
  input logic [CH_NUM-1:0][CNT_W-1:0]  cntFlat
);
  // R1
  start_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_W'(START_ADDR)) |-> (busRdata[CNT_W-1:CH_NUM] == '0));

  // R3
  sync_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_W'(SYNC_ADDR)) |-> (busRdata[CNT_W-1:CH_NUM] == '0));

  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReg == '0 && !(busSel && busWr)) |=> $stable(cntFlat));

  // R9
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReg == '0 && !(busSel && busWr)) |=> $stable(tmrOut));

  // R4
  grp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(CH_BASE) && syncReg[0] && syncReg[1])
    |=> (cntFlat[1] == $past(busWdata) && cntFlat[0] == $past(busWdata)));
endmodule

bind mtimer_top mtimer_chk #(
  .ADDR_W(ADDR_W), .START_ADDR(START_ADDR), .SYNC_ADDR(SYNC_ADDR), .CH_BASE(CH_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .tmrOut(tmrOut),
  .startReg(startReg), .syncReg(syncReg), .cntFlat(cntFlat)
);

// File: tb/mtimer_top_tb_top.sv
module mtimer_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [5:0]  tmrOut;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mtimer_top dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tmrOut(tmrOut)
  );

  // behavioural reference
  logic [15:0] mCnt[6], mCmpA[6], mCmpB[6], nCnt[6];
  logic [5:0]  mCtl[6];
  bit          mPin[6], nPin[6];
  bit [5:0]    mStart, mSync;
  bit          inG[6], wC[6], mA[6], mB[6], own[6];
  bit          anyW, anyOwn, grpOn, wEn;
  int          members;

  function automatic int chAddr(int c, int off);
    return 16 + 4 * c + off;
  endfunction

  function automatic logic [15:0] modelRead(int a);
    if (a == 0) return {10'b0, mStart};
    if (a == 1) return {10'b0, mSync};
    for (int c = 0; c < 6; c++) begin
      if (a == chAddr(c, 0)) return mCnt[c];
      if (a == chAddr(c, 1)) return mCmpA[c];
      if (a == chAddr(c, 2)) return mCmpB[c];
      if (a == chAddr(c, 3)) return {10'b0, mCtl[c]};
    end
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStart = '0; mSync = '0;
      for (int c = 0; c < 6; c++) begin
        mCnt[c] = 0; mCmpA[c] = 16'hFFFF; mCmpB[c] = 16'hFFFF; mCtl[c] = 0; mPin[c] = 0;
      end
    end else begin
      wEn = busSel && busWr;
      members = 0;
      for (int c = 0; c < 6; c++) members += mSync[c];
      grpOn = (members >= 2);
      anyW = 0; anyOwn = 0;
      for (int c = 0; c < 6; c++) begin
        inG[c] = grpOn && mSync[c];
        wC[c]  = wEn && (busAddr == chAddr(c, 0));
        if (inG[c] && wC[c]) anyW = 1;
        mA[c]  = mStart[c] && (mCnt[c] == mCmpA[c]);
        mB[c]  = mStart[c] && (mCnt[c] == mCmpB[c]);
        own[c] = (mCtl[c][2:0] == 1 && mA[c]) || (mCtl[c][2:0] == 2 && mB[c]);
        if (inG[c] && own[c]) anyOwn = 1;
      end
      for (int c = 0; c < 6; c++) begin
        if (wC[c] || (inG[c] && anyW)) nCnt[c] = busWdata;
        else if (own[c] || (mCtl[c][2:0] == 3 && inG[c] && anyOwn)) nCnt[c] = 0;
        else if (mStart[c]) nCnt[c] = mCnt[c] + 16'd1;
        else nCnt[c] = mCnt[c];
        nPin[c] = mPin[c];
        if (wEn && busAddr == chAddr(c, 3) && !mStart[c]) nPin[c] = busWdata[5];
        else if (mA[c]) begin
          case (mCtl[c][4:3])
            2'd1: nPin[c] = 0;
            2'd2: nPin[c] = 1;
            2'd3: nPin[c] = !mPin[c];
            default: nPin[c] = mPin[c];
          endcase
        end
      end
      for (int c = 0; c < 6; c++) begin
        mCnt[c] = nCnt[c];
        mPin[c] = nPin[c];
        if (wEn && busAddr == chAddr(c, 1)) mCmpA[c] = busWdata;
        if (wEn && busAddr == chAddr(c, 2)) mCmpB[c] = busWdata;
        if (wEn && busAddr == chAddr(c, 3)) mCtl[c] = busWdata[5:0];
      end
      if (wEn && busAddr == 0) mStart = busWdata[5:0];
      if (wEn && busAddr == 1) mSync = busWdata[5:0];
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R8 R9 pin comparison on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [15:0] pv;
      pv = '0;
      for (int c = 0; c < 6; c++) pv[c] = mPin[c];
      check("R8 R9 pins", {10'b0, tmrOut}, pv);
    end
  end

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 6'(a); busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 6'(a);
    #1;
    check(tag, busRdata, modelRead(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R5 reset values and map
    rd("R1 reset", 0);
    rd("R3 reset", 1);
    for (int c = 0; c < 6; c++)
      for (int o = 0; o < 4; o++) rd("R5 reset map", chAddr(c, o));
    // R1 padding
    wr(0, 16'h00FF);
    rd("R1 pad", 0);
    check("R1 literal", busRdata, 16'h003F);
    wr(0, 16'h0000);
    // R3 padding, single member does not broadcast
    wr(1, 16'h00C1);
    rd("R3 pad", 1);
    check("R3 literal", busRdata, 16'h0001);
    wr(chAddr(0, 0), 16'h1234);
    rd("R4 lone member", chAddr(1, 0));
    rd("R4 lone member self", chAddr(0, 0));
    // R4 active group broadcast
    wr(1, 16'h0007);
    wr(chAddr(1, 0), 16'h0100);
    for (int c = 0; c < 6; c++) rd("R4 group load", chAddr(c, 0));
    // R6 R7 R8 setup
    wr(chAddr(0, 1), 16'h0108); wr(chAddr(0, 3), 16'h0019);
    wr(chAddr(1, 1), 16'h0104); wr(chAddr(1, 3), 16'h0013);
    wr(chAddr(2, 3), 16'h0028);
    wr(chAddr(3, 1), 16'h0006); wr(chAddr(3, 3), 16'h0018);
    wr(chAddr(4, 1), 16'h0003); wr(chAddr(4, 3), 16'h0003);
    wr(chAddr(5, 2), 16'h0010); wr(chAddr(5, 3), 16'h0002);
    wr(0, 16'h003F);
    idle(30);
    for (int c = 0; c < 6; c++) rd("R2 R6 R7 run", chAddr(c, 0));
    idle(25);
    for (int c = 0; c < 6; c++) rd("R6 R7 later", chAddr(c, 0));
    // R9 halted
    wr(0, 16'h0000);
    idle(3);
    for (int c = 0; c < 6; c++) rd("R2 halted", chAddr(c, 0));
    wr(chAddr(0, 3), 16'h0039);
    wr(chAddr(3, 3), 16'h0018);
    idle(2);
    // R9 running write, R10 priority
    wr(0, 16'h003F);
    wr(chAddr(3, 3), 16'h0038);
    idle(2);
    rd("R8 ctl", chAddr(3, 3));
    wr(chAddr(0, 0), 16'h0107);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 6'(chAddr(0, 0)); busWdata = 16'h0108;
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 6'(chAddr(0, 0)); busWdata = 16'h0500;
    @(negedge clk);
    busSel = 0; busWr = 0;
    for (int c = 0; c < 3; c++) rd("R10 priority", chAddr(c, 0));
    // R2 wrap
    wr(chAddr(4, 1), 16'hFFFF);
    wr(chAddr(3, 0), 16'hFFFD);
    idle(3);
    rd("R2 wrap", chAddr(3, 0));
    idle(40);
    for (int c = 0; c < 6; c++) rd("R6 R7 R8 final", chAddr(c, 0));
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nErr++; nChk++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end
endmodule